// File: doc/BRIEF.md
# Packed Word Dot-Product Accumulator

This datapath unit folds two vectors of 16-bit elements into a vector of 32-bit accumulator lanes. For each 32-bit output lane it multiplies two adjacent pairs of 16-bit elements, one element taken from each source. It adds both products to the matching accumulator lane and writes the packed result. Per operation, the caller chooses how each source is extended, whether the lane sum wraps or clamps, and whether the full 256-bit vector or only its lower half is produced.

The unit sits behind an issue stage that supplies operands that are already decoded. A valid strobe marks each operation. The results come out with a valid strobe exactly two clock edges later, at a rate of one operation per cycle and with no stall path.

Top module: `wdot_accum`

## Requirements
- R1: Output lane j (bits 32j+31..32j) is formed from 16-bit elements 2j and 2j+1 of both sources (element i at bits 16i+15..16i) plus accumulator lane j.
- R2: With `in_mode` = 2'b00, elements of `src_a` are taken as signed and elements of `src_b` as unsigned, and the accumulator lane is read as signed.
- R3: With `in_mode` = 2'b01, elements of `src_a` are taken as unsigned and elements of `src_b` as signed, and the accumulator lane is read as signed.
- R4: With `in_mode` = 2'b10 or 2'b11, both sources and the accumulator lane are taken as unsigned.
- R5: With `in_sat` = 0, each lane result is the exact sum reduced modulo 2^32.
- R6: With `in_sat` = 1 in modes 2'b00 and 2'b01, a lane sum above 0x7FFFFFFF gives 0x7FFFFFFF, and a lane sum below -2^31 gives 0x80000000.
- R7: With `in_sat` = 1 in mode 2'b10 or 2'b11, a lane sum above 0xFFFFFFFF gives 0xFFFFFFFF. A lane whose accumulator has bit 31 set is not treated as negative.
- R8: Products and the three-term sum are formed at full precision, so a saturating result is clamped only when the final sum is out of range, whatever the size of either product alone.
- R9: With `in_wide` = 0, only lanes 0 to 3 are computed and bits 255..128 of the result are zero. With `in_wide` = 1, all eight lanes are computed.
- R10: An operation sampled with `in_valid` high at clock edge k sets `out_valid` and its result after edge k+1. Back-to-back operations are accepted every cycle.
- R11: A synchronous active-high `rst` clears `out_valid` and `out_vec` to zero.
- R12: `out_vec` holds its last value while no operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present on the inputs |
| in_mode | input | 2 | Source signedness: 00 signed×unsigned, 01 unsigned×signed, 1x unsigned×unsigned |
| in_sat | input | 1 | 1 = clamp the lane sum, 0 = wrap |
| in_wide | input | 1 | 1 = eight lanes, 0 = four lanes with the upper half zeroed |
| acc_vec | input | 256 | Accumulator lanes, 8 × 32 bits |
| src_a | input | 256 | First source, 16 × 16 bits |
| src_b | input | 256 | Second source, 16 × 16 bits |
| out_valid | output | 1 | Result present on `out_vec` |
| out_vec | output | 256 | Result lanes, 8 × 32 bits |

## Verification
The assertions assume that `in_mode`, `in_sat`, `in_wide` and all operands are known values (not X) whenever `in_valid` is high. They also assume that reset is held for at least one edge before the first operation. The stimulus drives every input to a defined value on every cycle, including idle cycles, and holds reset across two edges at the start. The lane lower-bound properties depend only on the sign of the pair sum, and the stimulus covers both signs in every mode through directed vectors and random vectors.

// File: rtl/wdot_pkg.sv
package wdot_pkg;

   typedef enum logic [1:0] {
      WD_SU     = 2'b00,
      WD_US     = 2'b01,
      WD_UU     = 2'b10,
      WD_UU_ALT = 2'b11
   } wd_mode_e;

   typedef struct packed {
      logic sat;
      logic uu;
      logic wide;
   } wd_ctrl_t;

   function automatic logic mode_a_signed(input logic [1:0] m);
      return m == WD_SU;
   endfunction

   function automatic logic mode_b_signed(input logic [1:0] m);
      return m == WD_US;
   endfunction

   function automatic logic mode_unsigned(input logic [1:0] m);
      return m[1];
   endfunction

endpackage

// File: rtl/wdot_pair_mul.sv
module wdot_pair_mul #(
   parameter int ELEM_W = 16,
   localparam int PROD_W = 2 * (ELEM_W + 1),
   localparam int PAIR_W = PROD_W + 1
) (
   input  logic [2*ELEM_W-1:0]      a_pair,
   input  logic [2*ELEM_W-1:0]      b_pair,
   input  logic                     a_sgn,
   input  logic                     b_sgn,
   output logic signed [PAIR_W-1:0] pair_sum
);

   if (ELEM_W < 2) begin : g_bad_elem
      $error("wdot_pair_mul: ELEM_W must be at least 2");
   end

   logic signed [PROD_W-1:0] prod [2];

   for (genvar k = 0; k < 2; k++) begin : g_prod
      logic signed [ELEM_W:0] ax;
      logic signed [ELEM_W:0] bx;
      assign ax = {a_sgn & a_pair[k*ELEM_W + ELEM_W-1], a_pair[k*ELEM_W +: ELEM_W]};
      assign bx = {b_sgn & b_pair[k*ELEM_W + ELEM_W-1], b_pair[k*ELEM_W +: ELEM_W]};
      assign prod[k] = ax * bx;
   end

   assign pair_sum = {prod[0][PROD_W-1], prod[0]} + {prod[1][PROD_W-1], prod[1]};

endmodule

// File: rtl/wdot_lane_fin.sv
module wdot_lane_fin #(
   parameter int ACC_W  = 32,
   parameter int PAIR_W = 35,
   localparam int WIDEST = (PAIR_W > ACC_W + 1) ? PAIR_W : ACC_W + 1,
   localparam int SUM_W  = WIDEST + 1
) (
   input  logic [ACC_W-1:0]         acc,
   input  logic signed [PAIR_W-1:0] pair_sum,
   input  logic                     uu,
   input  logic                     sat,
   output logic [ACC_W-1:0]         lane_out
);

   if (ACC_W < 2) begin : g_bad_acc
      $error("wdot_lane_fin: ACC_W must be at least 2");
   end

   logic                    acc_top;
   logic signed [SUM_W-1:0] acc_x;
   logic signed [SUM_W-1:0] pair_x;
   logic signed [SUM_W-1:0] sum;
   logic [SUM_W-ACC_W:0]    hi_bits;

   assign acc_top = ~uu & acc[ACC_W-1];
   assign acc_x   = {{(SUM_W-ACC_W){acc_top}}, acc};
   assign pair_x  = {{(SUM_W-PAIR_W){pair_sum[PAIR_W-1]}}, pair_sum};
   assign sum     = acc_x + pair_x;
   assign hi_bits = sum[SUM_W-1:ACC_W-1];

   always_comb begin
      lane_out = sum[ACC_W-1:0];
      if (sat) begin
         if (uu) begin
            if (sum[SUM_W-1])
               lane_out = '0;
            else if (|sum[SUM_W-2:ACC_W])
               lane_out = '1;
         end else if (!((&hi_bits) || !(|hi_bits))) begin
            lane_out = sum[SUM_W-1] ? {1'b1, {(ACC_W-1){1'b0}}}
                                    : {1'b0, {(ACC_W-1){1'b1}}};
         end
      end
   end

endmodule

// File: rtl/wdot_accum.sv
module wdot_accum
   import wdot_pkg::*;
#(
   parameter int LANES  = 8,
   parameter int ELEM_W = 16,
   parameter int ACC_W  = 32,
   localparam int VEC_W  = LANES * ACC_W,
   localparam int SRC_W  = 2 * LANES * ELEM_W,
   localparam int PAIR_W = 2 * (ELEM_W + 1) + 1,
   localparam int HALF   = LANES / 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [1:0]       in_mode,
   input  logic             in_sat,
   input  logic             in_wide,
   input  logic [VEC_W-1:0] acc_vec,
   input  logic [SRC_W-1:0] src_a,
   input  logic [SRC_W-1:0] src_b,
   output logic             out_valid,
   output logic [VEC_W-1:0] out_vec
);

   if (LANES < 2 || (LANES % 2) != 0) begin : g_bad_lanes
      $error("wdot_accum: LANES must be even and at least 2");
   end

   logic                     a_sgn, b_sgn;
   logic                     s1_valid;
   wd_ctrl_t                 s1_ctrl;
   logic [VEC_W-1:0]         s1_acc;
   logic signed [PAIR_W-1:0] pair_now [LANES];
   logic signed [PAIR_W-1:0] s1_pair  [LANES];
   logic [VEC_W-1:0]         lane_bus;

   assign a_sgn = mode_a_signed(in_mode);
   assign b_sgn = mode_b_signed(in_mode);

   // stage 1: products
   always_ff @(posedge clk) begin
      if (rst) s1_valid <= 1'b0;
      else     s1_valid <= in_valid;
   end

   always_ff @(posedge clk) begin
      if (in_valid) begin
         s1_ctrl.sat  <= in_sat;
         s1_ctrl.uu   <= mode_unsigned(in_mode);
         s1_ctrl.wide <= in_wide;
         s1_acc       <= acc_vec;
         s1_pair      <= pair_now;
      end
   end

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [ACC_W-1:0] fin;

      wdot_pair_mul #(.ELEM_W(ELEM_W)) mul_i (
         .a_pair   (src_a[j*2*ELEM_W +: 2*ELEM_W]),
         .b_pair   (src_b[j*2*ELEM_W +: 2*ELEM_W]),
         .a_sgn    (a_sgn),
         .b_sgn    (b_sgn),
         .pair_sum (pair_now[j])
      );

      wdot_lane_fin #(.ACC_W(ACC_W), .PAIR_W(PAIR_W)) fin_i (
         .acc      (s1_acc[j*ACC_W +: ACC_W]),
         .pair_sum (s1_pair[j]),
         .uu       (s1_ctrl.uu),
         .sat      (s1_ctrl.sat),
         .lane_out (fin)
      );

      if (j < HALF) begin : g_low
         assign lane_bus[j*ACC_W +: ACC_W] = fin;
      end else begin : g_high
         assign lane_bus[j*ACC_W +: ACC_W] = s1_ctrl.wide ? fin : '0;
      end

      // R7
      uu_sat_floor_chk: assert property (@(posedge clk) disable iff (rst)
         s1_valid && s1_ctrl.uu && s1_ctrl.sat && (j < HALF || s1_ctrl.wide)
         |=> out_vec[j*ACC_W +: ACC_W] >= $past(s1_acc[j*ACC_W +: ACC_W]));

      // R6
      mixed_sat_floor_chk: assert property (@(posedge clk) disable iff (rst)
         s1_valid && !s1_ctrl.uu && s1_ctrl.sat && !s1_pair[j][PAIR_W-1]
         && (j < HALF || s1_ctrl.wide)
         |=> $signed(out_vec[j*ACC_W +: ACC_W]) >= $signed($past(s1_acc[j*ACC_W +: ACC_W])));
   end

   // stage 2: accumulate, clamp, register
   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_vec   <= '0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid) out_vec <= lane_bus;
      end
   end

   // R10
   accept_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> s1_valid);

   // R10
   issue_chk: assert property (@(posedge clk) disable iff (rst)
      s1_valid |=> out_valid);

   // R10
   no_ghost_chk: assert property (@(posedge clk) disable iff (rst)
      !s1_valid |=> !out_valid);

   // R9
   narrow_zero_chk: assert property (@(posedge clk) disable iff (rst)
      s1_valid && !s1_ctrl.wide |=> out_vec[VEC_W-1:HALF*ACC_W] == '0);

   // R12
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      !s1_valid |=> $stable(out_vec));

endmodule

// File: tb/wdot_accum_tb.sv
module wdot_accum_tb_top;

   localparam int CLK_P = 10;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [1:0]   in_mode = 2'b00;
   logic         in_sat = 1'b0;
   logic         in_wide = 1'b1;
   logic [255:0] acc_vec = '0;
   logic [255:0] src_a = '0;
   logic [255:0] src_b = '0;
   logic         out_valid;
   logic [255:0] out_vec;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   logic         mv1 = 1'b0, mv_out = 1'b0;
   logic [255:0] md1 = '0, md_out = '0;

   always #(CLK_P/2) clk = ~clk;

   wdot_accum dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
      .in_sat(in_sat), .in_wide(in_wide), .acc_vec(acc_vec),
      .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .out_vec(out_vec)
   );

   function automatic logic [255:0] ref_calc(input logic [1:0] m, input logic s,
         input logic w, input logic [255:0] acc, input logic [255:0] a,
         input logic [255:0] b);
      logic [255:0] r = '0;
      for (int j = 0; j < 8; j++) begin
         longint sum, ac;
         if (!w && j >= 4) continue;
         ac = m[1] ? longint'(acc[32*j +: 32]) : longint'($signed(acc[32*j +: 32]));
         sum = ac;
         for (int k = 0; k < 2; k++) begin
            logic [15:0] ea, eb;
            longint xa, xb;
            ea = a[32*j + 16*k +: 16];
            eb = b[32*j + 16*k +: 16];
            xa = (m == 2'b00) ? longint'($signed(ea)) : longint'(ea);
            xb = (m == 2'b01) ? longint'($signed(eb)) : longint'(eb);
            sum += xa * xb;
         end
         if (s) begin
            if (m[1]) begin
               if (sum > 64'sd4294967295) sum = 64'sd4294967295;
            end else begin
               if (sum > 64'sd2147483647) sum = 64'sd2147483647;
               if (sum < -64'sd2147483648) sum = -64'sd2147483648;
            end
         end
         r[32*j +: 32] = sum[31:0];
      end
      return r;
   endfunction

   function automatic logic [255:0] rnd256();
      logic [255:0] v;
      for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
      return v;
   endfunction

   task automatic check(input string tag);
      n_checks++;
      if (out_valid !== mv_out || out_vec !== md_out) begin
         n_fail++;
         $display("FAIL %s: got v=%0b d=%h exp v=%0b d=%h",
                  tag, out_valid, out_vec, mv_out, md_out);
      end
   endtask

   task automatic step(input string tag, input logic v, input logic [1:0] m,
         input logic s, input logic w, input logic [255:0] acc,
         input logic [255:0] a, input logic [255:0] b);
      in_valid = v; in_mode = m; in_sat = s; in_wide = w;
      acc_vec = acc; src_a = a; src_b = b;
      @(posedge clk);
      if (mv1) md_out = md1;
      mv_out = mv1;
      mv1 = v;
      if (v) md1 = ref_calc(m, s, w, acc, a, b);
      @(negedge clk);
      check(tag);
   endtask

   task automatic idle(input string tag, input int n);
      for (int i = 0; i < n; i++) step(tag, 1'b0, 2'b00, 1'b0, 1'b1, '0, '0, '0);
   endtask

   task automatic do_reset(input string tag);
      rst = 1'b1; in_valid = 1'b0;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      mv1 = 1'b0; mv_out = 1'b0; md_out = '0;
      check(tag);
      rst = 1'b0;
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_fail++; n_checks++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [255:0] a, b, acc;
      @(negedge clk);
      do_reset("R11 reset state");

      // R1 lane pairing with distinct small elements
      for (int i = 0; i < 16; i++) begin
         a[16*i +: 16] = 16'(i + 1);
         b[16*i +: 16] = 16'(3 * i + 2);
      end
      for (int j = 0; j < 8; j++) acc[32*j +: 32] = 32'(1000 * j);
      step("R1 pairing", 1'b1, 2'b10, 1'b0, 1'b1, acc, a, b);
      idle("R1 drain", 2);

      // R2 signed a, unsigned b
      a = {16{16'h8001}}; b = {16{16'hFFFF}}; acc = {8{32'h0000_0010}};
      step("R2 su", 1'b1, 2'b00, 1'b0, 1'b1, acc, a, b);
      a = {16{16'hFFFE}}; b = {16{16'h7000}}; acc = {8{32'hFFFF_FF00}};
      step("R2 su neg acc", 1'b1, 2'b00, 1'b1, 1'b1, acc, a, b);
      // R3 unsigned a, signed b
      a = {16{16'hFFFF}}; b = {16{16'h8001}};
      step("R3 us", 1'b1, 2'b01, 1'b0, 1'b1, acc, a, b);
      // R4 both unsigned, both encodings
      a = {16{16'hFFFF}}; b = {16{16'hFFFF}}; acc = {8{32'h0000_0001}};
      step("R4 uu 10", 1'b1, 2'b10, 1'b0, 1'b1, acc, a, b);
      a = {16{16'hC000}}; b = {16{16'h8000}};
      step("R4 uu 11", 1'b1, 2'b11, 1'b0, 1'b1, acc, a, b);
      idle("R4 drain", 2);

      // R5 wrap
      a = {16{16'h0001}}; b = {16{16'h0001}}; acc = {8{32'h7FFF_FFFF}};
      step("R5 wrap mixed", 1'b1, 2'b00, 1'b0, 1'b1, acc, a, b);
      a = {16{16'hFFFF}}; b = {16{16'hFFFF}}; acc = {8{32'hFFFF_FFF0}};
      step("R5 wrap uu", 1'b1, 2'b10, 1'b0, 1'b1, acc, a, b);
      // R6 signed clamp, both directions
      a = {16{16'h0001}}; b = {16{16'h0001}}; acc = {8{32'h7FFF_FFFF}};
      step("R6 clamp hi", 1'b1, 2'b00, 1'b1, 1'b1, acc, a, b);
      a = {16{16'hFFFF}}; b = {16{16'h8000}}; acc = {8{32'h8000_0000}};
      step("R6 clamp lo", 1'b1, 2'b01, 1'b1, 1'b1, acc, a, b);
      // R7 unsigned clamp and no signed misread
      a = {16{16'hFFFF}}; b = {16{16'hFFFF}}; acc = {8{32'hFFFF_FFF0}};
      step("R7 uu clamp", 1'b1, 2'b10, 1'b1, 1'b1, acc, a, b);
      a = {16{16'h0002}}; b = {16{16'h0003}}; acc = {8{32'h8000_0000}};
      step("R7 uu high acc", 1'b1, 2'b11, 1'b1, 1'b1, acc, a, b);
      // R8 large products, in-range total
      a = {16{16'h8000}}; b = {16{16'hFFFF}}; acc = {8{32'h7FFF_FFFF}};
      step("R8 full precision", 1'b1, 2'b00, 1'b1, 1'b1, acc, a, b);
      idle("R8 drain", 2);

      // R9 narrow form
      a = rnd256(); b = rnd256(); acc = rnd256();
      step("R9 narrow", 1'b1, 2'b00, 1'b0, 1'b0, acc, a, b);
      step("R9 narrow sat", 1'b1, 2'b10, 1'b1, 1'b0, acc, a, b);
      step("R9 wide", 1'b1, 2'b01, 1'b0, 1'b1, acc, a, b);
      // R12 hold over idle cycles
      idle("R12 hold", 4);

      // R10 random traffic with gaps
      for (int t = 0; t < 400; t++) begin
         logic [1:0] m;
         m = 2'($urandom);
         step("R10 stream", 1'($urandom % 4 != 0), m, 1'($urandom), 1'($urandom),
              rnd256(), rnd256(), rnd256());
      end
      idle("R10 drain", 3);

      // R11 reset after traffic
      step("R11 preload", 1'b1, 2'b10, 1'b0, 1'b1, rnd256(), rnd256(), rnd256());
      step("R11 preload", 1'b0, 2'b10, 1'b0, 1'b1, '0, '0, '0);
      do_reset("R11 mid reset");
      idle("R11 after", 2);

      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule